// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block keeps the pending-event flags and the matching enable mask for a small peripheral that has two timers and a serial shift unit. Each event source raises its flag with a one-cycle pulse. A flag then stays set until software clears it. Software can clear a flag by writing a one to its position in the flag register. A neighbouring block can also clear flags through a side-clear vector, for example when a counter or the shift data is read.

Software changes the enable mask with single writes. The top bit of the written byte selects the action. When it is one, the written low bits are set in the mask. When it is zero, the written low bits are cleared from the mask, and all other mask bits stay as they are.

The block drives a single level interrupt line. The line is high while a shift-complete, timer-2 or timer-1 flag is set and its enable bit is also set. When the flag register is read, its top bit shows a summary: it is one whenever any flag is set together with its enable bit.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, every flag and every enable bit is zero and `irq` is low. A read of the flag register returns 0x00, and a read of the enable register returns 0x80.
- R2: A pulse on `ev_pulse[k]` sets flag bit k at the clock edge that samples the pulse. The implemented positions are: 2 for shift complete, 3 for shift data, 4 for shift clock, 5 for timer 2 and 6 for timer 1. Pulses on bits 0 and 1 are ignored. A flag holds its value until it is cleared.
- R3: A write to register index 0xD clears each flag whose bit in `wr_data[6:0]` is 1. The other flags are unchanged.
- R4: A one on `side_clr[k]` clears flag k at that clock edge.
- R5: If a set pulse and a clear (by write or by side-clear) hit the same flag in the same cycle, the flag ends up set.
- R6: A write to index 0xE with `wr_data[7]`=1 ORs `wr_data[6:0]` into the enable mask.
- R7: A write to index 0xE with `wr_data[7]`=0 clears the enable bits where `wr_data[6:0]` is 1. The other enable bits are unchanged.
- R8: A read of index 0xE returns the enable mask in bits 6:0, with bit 7 always set to 1.
- R9: A read of index 0xD returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag is set and its enable bit is also set.
- R10: `irq` is high exactly while flag and enable share a set bit at position 2, 5 or 6. Positions 3 and 4 never drive `irq`.
- R11: `rd_data` is registered. It shows the addressed register one cycle after the `reg_rd` strobe and holds until the next strobe. Any other index reads as 0x00, and writes to any other index change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 4 | Register index |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| ev_pulse | input | 7 | Event set pulses, one bit per flag position |
| side_clr | input | 7 | Flag clear requests from neighbouring blocks |
| irq | output | 1 | Level interrupt request |

## Verification
Set pulses, clear writes, side clears and enable writes all take effect at the clock edge that samples them. The flags and the enable mask are visible on `irq` right after that edge, because `irq` is computed from the two registers without a further register stage. Register contents reach `rd_data` one edge after the read strobe. The bench drives every stimulus at a falling edge and releases it at the next falling edge. It then samples `irq` at that falling edge, and it reads registers through a strobe whose result it samples one falling edge later. With this scheme every comparison lands half a cycle after the edge that produced the value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Flag positions; the interrupt and summary logic depend on them
   localparam int POS_SHIFT_DONE = 2;
   localparam int POS_SHIFT_DATA = 3;
   localparam int POS_SHIFT_CLK  = 4;
   localparam int POS_TMR2       = 5;
   localparam int POS_TMR1       = 6;

   localparam int unsigned DEF_FLAG_MASK =
      (1 << POS_SHIFT_DONE) | (1 << POS_SHIFT_DATA) | (1 << POS_SHIFT_CLK) |
      (1 << POS_TMR2) | (1 << POS_TMR1);
   localparam int unsigned DEF_IRQ_MASK =
      (1 << POS_SHIFT_DONE) | (1 << POS_TMR2) | (1 << POS_TMR1);

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_FLAG = 2'd1,
      SEL_ENA  = 2'd2
   } sel_e;

endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
   parameter int unsigned SRC_W = 7,
   parameter logic [SRC_W-1:0] MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] set_vec,
   input  logic [SRC_W-1:0] clr_vec,
   output logic [SRC_W-1:0] flag_q
);

   for (genvar gi = 0; gi < SRC_W; gi++) begin : g_bit
      localparam logic IMPL = MASK[gi];

      // Set has priority over clear so that no event is lost
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_q[gi] <= 1'b0;
         else if (set_vec[gi] && IMPL)
            flag_q[gi] <= 1'b1;
         else if (clr_vec[gi])
            flag_q[gi] <= 1'b0;
      end

      if (IMPL) begin : g_chk
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[gi] |=> flag_q[gi]); // R5
         AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[gi] && !set_vec[gi]) |=> !flag_q[gi]); // R3
         AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_vec[gi] && !set_vec[gi]) |=> $stable(flag_q[gi])); // R2
      end
   end

endmodule

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned SRC_W = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [SRC_W-1:0]  ena_q
);

   logic             op_set;
   logic [SRC_W-1:0] op_bits;

   assign op_set  = wr_data[DATA_W-1];
   assign op_bits = wr_data[SRC_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ena_q <= '0;
      else if (wr_en)
         ena_q <= op_set ? (ena_q | op_bits) : (ena_q & ~op_bits);
   end

   AST_ENA_OR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op_set) |=> ((ena_q & $past(op_bits)) == $past(op_bits))); // R6
   AST_ENA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !op_set) |=> ((ena_q & $past(op_bits)) == '0)); // R7
   AST_ENA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ena_q)); // R7

endmodule

// File: rtl/irqc_rd_port.sv
module irqc_rd_port
   import irqc_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter bit RD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  sel_e              sel,
   input  logic [DATA_W-1:0] flag_word,
   input  logic [DATA_W-1:0] ena_word,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mux_val;

   always_comb begin
      unique case (sel)
         SEL_FLAG: mux_val = flag_word;
         SEL_ENA:  mux_val = ena_word;
         default:  mux_val = '0;
      endcase
   end

   if (RD_REG) begin : g_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rd_q <= '0;
         else if (rd_en)
            rd_q <= mux_val;
      end
      assign rd_data = rd_q;

      AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en |=> $stable(rd_data)); // R11
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk & rst_n;
      assign rd_data = rd_en ? mux_val : '0;
   end

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned FLAG_IDX  = 13,
   parameter int unsigned ENA_IDX   = 14,
   parameter int unsigned FLAG_MASK = DEF_FLAG_MASK,
   parameter int unsigned IRQ_MASK  = DEF_IRQ_MASK,
   parameter bit          RD_REG    = 1'b1,
   localparam int unsigned SRC_W    = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  reg_sel,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [SRC_W-1:0]  ev_pulse,
   input  logic [SRC_W-1:0]  side_clr,
   output logic              irq
);

   localparam logic [SRC_W-1:0] FMASK = SRC_W'(FLAG_MASK);
   localparam logic [SRC_W-1:0] IMASK = SRC_W'(IRQ_MASK);
   localparam logic [IDX_W-1:0] F_IDX = IDX_W'(FLAG_IDX);
   localparam logic [IDX_W-1:0] E_IDX = IDX_W'(ENA_IDX);

   // Elaboration-time parameter checks
   if (DATA_W < 8) begin : g_bad_width
      $error("irq_flag_ctrl: DATA_W must be at least 8");
   end
   if (FLAG_IDX == ENA_IDX) begin : g_bad_idx
      $error("irq_flag_ctrl: flag and enable indices collide");
   end
   if ((FLAG_IDX >> IDX_W) != 0 || (ENA_IDX >> IDX_W) != 0) begin : g_bad_range
      $error("irq_flag_ctrl: register index exceeds IDX_W");
   end
   if ((IRQ_MASK & ~FLAG_MASK) != 0) begin : g_bad_mask
      $error("irq_flag_ctrl: IRQ_MASK names an unimplemented flag");
   end

   sel_e             sel;
   logic             wr_flag;
   logic             wr_ena;
   logic [SRC_W-1:0] clr_vec;
   logic [SRC_W-1:0] flag_q;
   logic [SRC_W-1:0] ena_q;
   logic             pend_any;

   always_comb begin
      if (reg_sel == F_IDX)      sel = SEL_FLAG;
      else if (reg_sel == E_IDX) sel = SEL_ENA;
      else                       sel = SEL_NONE;
   end

   assign wr_flag = reg_wr && (sel == SEL_FLAG);
   assign wr_ena  = reg_wr && (sel == SEL_ENA);
   assign clr_vec = (wr_flag ? wr_data[SRC_W-1:0] : '0) | side_clr;

   irqc_flag_bank #(
      .SRC_W (SRC_W),
      .MASK  (FMASK)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (ev_pulse),
      .clr_vec (clr_vec),
      .flag_q  (flag_q)
   );

   irqc_enable_reg #(
      .DATA_W (DATA_W)
   ) u_ena (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ena),
      .wr_data (wr_data),
      .ena_q   (ena_q)
   );

   assign pend_any = |(flag_q & ena_q);
   assign irq      = |(flag_q & ena_q & IMASK);

   irqc_rd_port #(
      .DATA_W (DATA_W),
      .RD_REG (RD_REG)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (reg_rd),
      .sel       (sel),
      .flag_word ({pend_any, flag_q}),
      .ena_word  ({1'b1, ena_q}),
      .rd_data   (rd_data)
   );

   AST_IRQ_NEEDS_ENA: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((ena_q & IMASK) != '0)); // R10
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((flag_q & IMASK) != '0)); // R10
   AST_SIDE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (side_clr != '0 && ev_pulse == '0) |=> ((flag_q & $past(side_clr)) == '0)); // R4

   if (RD_REG) begin : g_rd_chk
      AST_ENA_RD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_rd && reg_sel == E_IDX) |=> rd_data[DATA_W-1]); // R8
   end

endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] reg_sel = '0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [6:0] ev_pulse = '0;
   logic [6:0] side_clr = '0;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [3:0] FI = 4'hD;
   localparam logic [3:0] EI = 4'hE;
   localparam logic [6:0] IMPL = 7'h7C;
   localparam logic [6:0] IRQB = 7'h64;

   always #10 clk = ~clk;

   irq_flag_ctrl u_irq_flag_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_sel  (reg_sel),
      .reg_wr   (reg_wr),
      .reg_rd   (reg_rd),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .ev_pulse (ev_pulse),
      .side_clr (side_clr),
      .irq      (irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [3:0] idx, input logic [7:0] d);
      @(negedge clk);
      reg_sel = idx; wr_data = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [3:0] idx, output logic [7:0] d);
      @(negedge clk);
      reg_sel = idx; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = rd_data;
   endtask

   task automatic pulse(input logic [6:0] ev);
      @(negedge clk);
      ev_pulse = ev;
      @(negedge clk);
      ev_pulse = '0;
   endtask

   function automatic logic [7:0] flag_word(input logic [6:0] f, input logic [6:0] e);
      return {|(f & e), f};
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v;
      logic [6:0] f;
      logic [6:0] e;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 irq", int'(irq), 0);
      chk("R1 rd_data", int'(rd_data), 0);
      rst_n = 1'b1;
      do_rd(FI, v); chk("R1 flag read", v, 8'h00);
      do_rd(EI, v); chk("R1 ena read", v, 8'h80);
      chk("R1 irq after", int'(irq), 0);

      // R2 single-bit sets, bits 0/1 ignored, hold
      for (int k = 0; k < 7; k++) begin
         do_wr(FI, 8'h7F);
         pulse(7'(1 << k));
         repeat (3) @(negedge clk);
         do_rd(FI, v);
         chk($sformatf("R2 set bit %0d", k), v, {1'b0, 7'(1 << k) & IMPL});
      end

      // R11 read timing/hold and other index
      do_wr(FI, 8'h7F);
      pulse(7'h40);
      @(negedge clk); reg_sel = FI; reg_rd = 1'b1;
      @(negedge clk); reg_rd = 1'b0; chk("R11 read one cycle later", rd_data, 8'h40);
      reg_sel = EI;
      @(negedge clk); chk("R11 read data holds", rd_data, 8'h40);
      do_rd(4'h3, v); chk("R11 other index reads zero", v, 8'h00);
      do_wr(4'h3, 8'hFF);
      do_wr(4'hF, 8'hFF);
      do_rd(FI, v); chk("R11 stray write flag", v, 8'h40);
      do_rd(EI, v); chk("R11 stray write ena", v, 8'h80);

      // R6/R7 OR and clear preserve others
      do_wr(EI, 8'h80 | 8'h11);
      do_wr(EI, 8'h80 | 8'h22);
      do_rd(EI, v); chk("R6 OR keeps prior", v, 8'hB3);
      do_wr(EI, 8'h01);
      do_rd(EI, v); chk("R7 clear one bit", v, 8'hB2);
      for (int m = 0; m < 128; m += 3) begin
         do_wr(EI, 8'hFF);
         do_wr(EI, {1'b0, 7'(m)});
         do_rd(EI, v);
         chk("R7 clear sweep", v, {1'b1, 7'h7F & ~7'(m)});
      end

      // R3 clear sweep with enables off
      do_wr(EI, 8'h7F);
      for (int c = 0; c < 128; c += 5) begin
         pulse(7'h7F);
         do_wr(FI, {1'b1, 7'(c)});
         do_rd(FI, v);
         chk("R3 clear sweep", v, {1'b0, IMPL & ~7'(c)});
         do_wr(FI, 8'h7F);
      end

      // R4 side clear
      pulse(7'h7C);
      @(negedge clk); side_clr = 7'h0C;
      @(negedge clk); side_clr = '0;
      do_rd(FI, v); chk("R4 side clear", v, 8'h70);

      // R5 set beats write clear and side clear in the same cycle
      do_wr(FI, 8'h7F);
      pulse(7'h20);
      @(negedge clk);
      ev_pulse = 7'h40; side_clr = 7'h04;
      reg_sel = FI; wr_data = 8'h60; reg_wr = 1'b1;
      @(negedge clk);
      ev_pulse = '0; side_clr = '0; reg_wr = 1'b0;
      do_rd(FI, v); chk("R5 set wins write", v, 8'h40);
      @(negedge clk); ev_pulse = 7'h04; side_clr = 7'h04;
      @(negedge clk); ev_pulse = '0; side_clr = '0;
      do_rd(FI, v); chk("R5 set wins side", v, 8'h44);

      // R8 R9 R10 sweep over enables x flag patterns
      for (int ei = 0; ei < 128; ei++) begin
         e = 7'(ei);
         do_wr(EI, 8'h7F);
         do_wr(EI, {1'b1, e});
         do_rd(EI, v);
         chk("R8 ena read bit7", v, {1'b1, e});
         for (int fi = 0; fi < 128; fi += 9) begin
            f = 7'(fi) & IMPL;
            do_wr(FI, 8'h7F);
            pulse(7'(fi));
            chk("R10 irq level", int'(irq), int'(|(f & e & IRQB)));
            do_rd(FI, v);
            chk("R9 flag read summary", v, flag_word(f, e));
         end
      end

      // R10 bits 3,4 never drive irq
      do_wr(EI, 8'hFF);
      do_wr(FI, 8'h7F);
      pulse(7'h18);
      chk("R10 shift data/clock no irq", int'(irq), 0);
      do_rd(FI, v); chk("R9 summary from bits 3,4", v, 8'h98);
      pulse(7'h04);
      chk("R10 shift done irq", int'(irq), 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule